// File: doc/BRIEF.md
# Dual-Channel Converter Serial Frame Reader

This block is the host side of a link to a two-channel, simultaneously sampling 16-bit successive-approximation converter that is read as a serial slave. When asked to sample, it pulls the convert-start line low for a set number of system clocks. That falling edge puts both sample-and-hold stages into hold. The block then watches the converter's busy line. It waits until busy has been seen high and has fallen again, which marks the end of both channel conversions.

Next it selects the converter by driving chip select and read low together, and it generates a serial clock from the system clock. It shifts in a 32-bit frame, most significant bit first. The frame is split into two 16-bit words. A channel-order setting, taken when the sample request is accepted, tells which half of the frame is channel A, and the same setting is passed to the converter. Both words are presented on fixed channel-A and channel-B outputs with a one-cycle valid strobe.

If busy does not end within a set window, the block gives up and pulses a timeout flag. A synchronous reset aborts any conversion or read in progress and drops the partial frame.

Top module: `dual_adc_reader`

## Requirements
- R1: After an accepted request, `cnv_n_o` is low for exactly CNV_LOW_CYC system clock cycles and is high at all other times.
- R2: A request on `start_i` is accepted only while the block is idle (`ready_o` high) and `busy_i` is low; otherwise it has no effect.
- R3: `cs_n_o` and `rd_n_o` go low only after `busy_i` has been seen high during the current conversion and has then fallen, and they never go low while `cnv_n_o` is low.
- R4: `sclk_o` rests low and toggles only while the converter is selected. Each level lasts SCLK_HALF system clocks, and a frame has exactly 32 rising edges. The converter changes data after a falling edge, and the block samples `sdata_i` at each rising edge, taking bit 31 first.
- R5: `order_o` carries the value of `order_a_first_i` captured at the accepted request, and it stays stable for the whole read. When it is 1, frame bits 31..16 are channel A and bits 15..0 are channel B. When it is 0, the halves are swapped. `ch_a_o` always shows channel A and `ch_b_o` always shows channel B.
- R6: `valid_o` is high for exactly one cycle per completed frame, raised on the clock edge that samples the last bit. `ch_a_o` and `ch_b_o` keep their values until the next valid strobe.
- R7: If busy has not ended within BUSY_TIMEOUT cycles of the convert-start falling edge, `timeout_o` pulses for one cycle exactly BUSY_TIMEOUT cycles after that edge. The block then returns to idle without starting a read.
- R8: A high `rst` ends any conversion or read at the next edge: `cnv_n_o`, `cs_n_o` and `rd_n_o` go high, `sclk_o` goes low, and no valid strobe is raised for the partial frame. The next frame after reset is read correctly.
- R9: `sdata_i` has no effect while the converter is deselected.
- R10: After reset, `cnv_n_o`, `cs_n_o` and `rd_n_o` are high, `sclk_o`, `valid_o` and `timeout_o` are low, and `ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset and abort |
| start_i | input | 1 | Request one two-channel sample and read |
| order_a_first_i | input | 1 | Channel order for the next frame (1: A first) |
| busy_i | input | 1 | Converter busy indication |
| sdata_i | input | 1 | Converter serial data |
| cnv_n_o | output | 1 | Convert start, active low |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read enable, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| order_o | output | 1 | Latched channel order, driven to the converter |
| ch_a_o | output | 16 | Channel A word |
| ch_b_o | output | 16 | Channel B word |
| valid_o | output | 1 | One-cycle strobe for a new word pair |
| timeout_o | output | 1 | One-cycle strobe when busy does not end in time |
| ready_o | output | 1 | Idle and able to accept a request |

## Verification
The bench builds the block with CNV_LOW_CYC=3, SCLK_HALF=2 and BUSY_TIMEOUT=40. With a three-cycle convert pulse, the width check can tell an exact width apart from an off-by-one. With a two-clock half period, the divider counter is exercised, not just a plain toggle. The short timeout window lets a stuck-busy case reach the error path within a few dozen cycles and lets the bench measure its exact distance. Conversion lengths drawn at random, up to 20 cycles, stay well inside that window, so normal frames and timeout frames remain separate.

// File: rtl/dar_pkg.sv
package dar_pkg;

    localparam int DAR_WORD_W  = 16;
    localparam int DAR_FRAME_W = 2 * DAR_WORD_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_WAIT,
        ST_READ,
        ST_TAIL
    } dar_state_e;

    typedef struct packed {
        logic [DAR_WORD_W-1:0] a;
        logic [DAR_WORD_W-1:0] b;
    } dar_pair_t;

    // Upper half arrives first; order selects which channel it belongs to.
    function automatic dar_pair_t dar_split(input logic [DAR_FRAME_W-1:0] f,
                                            input logic a_first);
        dar_pair_t p;
        if (a_first) begin
            p.a = f[DAR_FRAME_W-1:DAR_WORD_W];
            p.b = f[DAR_WORD_W-1:0];
        end else begin
            p.b = f[DAR_FRAME_W-1:DAR_WORD_W];
            p.a = f[DAR_WORD_W-1:0];
        end
        return p;
    endfunction

endpackage

// File: rtl/dar_sclk_gen.sv
module dar_sclk_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          sclk_q;
    logic          tick;

    assign tick   = en && (cnt_q == CW'(HALF - 1));
    assign rise_o = tick && !sclk_q;
    assign fall_o = tick && sclk_q;
    assign sclk_o = sclk_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (tick) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dar_shift_capture.sv
module dar_shift_capture #(
    parameter int BITS = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            shift_en,
    input  logic            sdata_i,
    output logic [BITS-1:0] frame_o,
    output logic            last_o
);
    localparam int CW = $clog2(BITS);

    logic [CW-1:0]   left_q;
    logic [BITS-1:0] sh_q;

    assign frame_o = sh_q;
    assign last_o  = (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            left_q <= CW'(BITS - 1);
            sh_q   <= '0;
        end else if (shift_en) begin
            sh_q   <= {sh_q[BITS-2:0], sdata_i};
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/dar_busy_timer.sv
module dar_busy_timer #(
    parameter int LIMIT = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic expire_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign expire_o = run && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (run && !expire_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader
    import dar_pkg::*;
#(
    parameter int CNV_LOW_CYC  = 2,
    parameter int SCLK_HALF    = 2,
    parameter int BUSY_TIMEOUT = 200
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic                  order_a_first_i,
    input  logic                  busy_i,
    input  logic                  sdata_i,
    output logic                  cnv_n_o,
    output logic                  cs_n_o,
    output logic                  rd_n_o,
    output logic                  sclk_o,
    output logic                  order_o,
    output logic [DAR_WORD_W-1:0] ch_a_o,
    output logic [DAR_WORD_W-1:0] ch_b_o,
    output logic                  valid_o,
    output logic                  timeout_o,
    output logic                  ready_o
);
    localparam int CCW = (CNV_LOW_CYC > 1) ? $clog2(CNV_LOW_CYC) : 1;

    dar_state_e             state_q, state_d;
    logic [CCW-1:0]         conv_cnt_q;
    logic                   order_q;
    logic                   seen_busy_q;
    logic                   valid_q;
    logic                   timeout_q;
    dar_pair_t              pair_q;

    logic                   accept;
    logic                   waiting;
    logic                   selected;
    logic                   expire;
    logic                   rise, fall;
    logic                   last_bit;
    logic [DAR_FRAME_W-1:0] frame;
    logic                   frame_done;
    logic                   to_read;

    assign accept     = (state_q == ST_IDLE) && start_i && !busy_i;
    assign waiting    = (state_q == ST_CONV) || (state_q == ST_WAIT);
    assign selected   = (state_q == ST_READ) || (state_q == ST_TAIL);
    assign frame_done = (state_q == ST_READ) && rise && last_bit;
    assign to_read    = (state_q == ST_WAIT) && seen_busy_q && !busy_i;

    dar_sclk_gen #(.HALF(SCLK_HALF)) u_sclk (
        .clk    (clk),
        .rst    (rst),
        .en     (selected),
        .sclk_o (sclk_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    dar_shift_capture #(.BITS(DAR_FRAME_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .shift_en ((state_q == ST_READ) && rise),
        .sdata_i  (sdata_i),
        .frame_o  (frame),
        .last_o   (last_bit)
    );

    dar_busy_timer #(.LIMIT(BUSY_TIMEOUT)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .run      (waiting),
        .expire_o (expire)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_CONV;
            ST_CONV: begin
                if (expire)                                 state_d = ST_IDLE;
                else if (conv_cnt_q == CCW'(CNV_LOW_CYC-1)) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (to_read)     state_d = ST_READ;
                else if (expire) state_d = ST_IDLE;
            end
            ST_READ: if (frame_done) state_d = ST_TAIL;
            ST_TAIL: if (fall)       state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            conv_cnt_q  <= '0;
            order_q     <= 1'b0;
            seen_busy_q <= 1'b0;
            valid_q     <= 1'b0;
            timeout_q   <= 1'b0;
            pair_q      <= '0;
        end else begin
            state_q   <= state_d;
            valid_q   <= frame_done;
            timeout_q <= expire && !to_read;
            if (accept) begin
                order_q     <= order_a_first_i;
                conv_cnt_q  <= '0;
                seen_busy_q <= 1'b0;
            end else begin
                if (state_q == ST_CONV) conv_cnt_q <= conv_cnt_q + 1'b1;
                if (waiting && busy_i)  seen_busy_q <= 1'b1;
            end
            if (frame_done) begin
                pair_q <= dar_split({frame[DAR_FRAME_W-2:0], sdata_i}, order_q);
            end
        end
    end

    assign cnv_n_o   = (state_q != ST_CONV);
    assign cs_n_o    = !selected;
    assign rd_n_o    = !((state_q == ST_READ) || (state_q == ST_TAIL));
    assign order_o   = order_q;
    assign ch_a_o    = pair_q.a;
    assign ch_b_o    = pair_q.b;
    assign valid_o   = valid_q;
    assign timeout_o = timeout_q;
    assign ready_o   = (state_q == ST_IDLE);

endmodule

// File: rtl/dar_checker.sv
module dar_checker (
    input logic        clk,
    input logic        rst,
    input logic        busy_i,
    input logic        cnv_n_o,
    input logic        cs_n_o,
    input logic        sclk_o,
    input logic        order_o,
    input logic        valid_o,
    input logic        timeout_o
);
    assert_start_needs_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(cnv_n_o) |-> !$past(busy_i));

    assert_no_read_in_conv_R3: assert property (@(posedge clk) disable iff (rst)
        !cs_n_o |-> cnv_n_o);

    assert_read_after_busy_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> !$past(busy_i));

    assert_sclk_only_selected_R4: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> !cs_n_o);

    assert_order_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_o && $past(!cs_n_o)) |-> $stable(order_o));

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    assert_valid_in_read_R6: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> !cs_n_o);

    assert_timeout_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> (cs_n_o && cnv_n_o && !valid_o));

    assert_abort_R8: assert property (@(posedge clk)
        $past(rst) |-> (cs_n_o && cnv_n_o && !sclk_o && !valid_o && !timeout_o));
endmodule

bind dual_adc_reader dar_checker chk (.*);

// File: tb/dual_adc_reader_test.sv
module dual_adc_reader_test;
    localparam int CLK_PERIOD = 10;
    localparam int T_CNV      = 3;
    localparam int T_HALF     = 2;
    localparam int T_TO       = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic order_in = 1'b1;
    logic force_busy = 1'b0;
    logic sdata = 1'b0;
    logic cnv_n, cs_n, rd_n, sclk, order_o, valid, tmo, ready;
    logic [15:0] ch_a, ch_b;

    // converter model state
    logic        m_busy = 1'b0, m_hang = 1'b0, busy_done = 1'b0;
    int          m_left = 0, conv_len = 5, m_idx = 31;
    logic [31:0] m_frame = '0;
    logic [15:0] next_a = '0, next_b = '0;
    logic        p_cnv = 1'b1, p_cs = 1'b1, p_sclk = 1'b0;

    // monitors
    int cyc = 0, cnv_w = 0, last_w = 0, rises = 0, falls = 0, r3_bad = 0;
    int vcount = 0, tcount = 0, cnv_falls = 0, cs_falls = 0, fall_cyc = 0, to_cyc = 0;
    logic [15:0] cap_a = '0, cap_b = '0;

    int n_tests = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_adc_reader #(.CNV_LOW_CYC(T_CNV), .SCLK_HALF(T_HALF), .BUSY_TIMEOUT(T_TO)) uut (
        .clk(clk), .rst(rst), .start_i(start), .order_a_first_i(order_in),
        .busy_i(m_busy | force_busy), .sdata_i(sdata),
        .cnv_n_o(cnv_n), .cs_n_o(cs_n), .rd_n_o(rd_n), .sclk_o(sclk), .order_o(order_o),
        .ch_a_o(ch_a), .ch_b_o(ch_b), .valid_o(valid), .timeout_o(tmo), .ready_o(ready));

    function automatic logic [31:0] exp_frame(input logic [15:0] a, input logic [15:0] b,
                                              input logic a_first);
        return a_first ? {a, b} : {b, a};
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (p_cnv && !cnv_n) begin
            m_busy = 1'b1; m_left = conv_len; busy_done = 1'b0;
            cnv_falls++; fall_cyc = cyc; cnv_w = 0;
        end else if (m_busy && !m_hang) begin
            if (m_left <= 1) begin
                m_busy = 1'b0; busy_done = 1'b1;
                m_frame = exp_frame(next_a, next_b, order_o);
            end else m_left--;
        end
        if (!cnv_n) cnv_w++;
        if (!p_cnv && cnv_n) last_w = cnv_w;
        if (p_cs && !cs_n) begin
            m_idx = 31; cs_falls++;
            if (!busy_done) r3_bad++;
        end else if (!cs_n && p_sclk && !sclk && m_idx > 0) m_idx--;
        if (!p_sclk && sclk) rises++;
        if (p_sclk && !sclk) falls++;
        if (valid) begin vcount++; cap_a = ch_a; cap_b = ch_b; end
        if (tmo) begin tcount++; to_cyc = cyc; end
        // R9: garbage while deselected
        sdata = (!cs_n && !rd_n) ? m_frame[m_idx] : 1'($urandom % 2);
        p_cnv = cnv_n; p_cs = cs_n; p_sclk = sclk;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        rises = 0; falls = 0; r3_bad = 0; vcount = 0; tcount = 0;
        cnv_falls = 0; cs_falls = 0; last_w = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (ready && cs_n && !m_busy) break;
        end
    endtask

    task automatic run_frame(input logic [15:0] a, input logic [15:0] b, input logic ord,
                             input int len, input bit flip, input bit poke);
        next_a = a; next_b = b; conv_len = len; order_in = ord;
        clear_mon();
        pulse_start();
        for (int i = 0; i < 3000 && cs_n; i++) @(negedge clk);
        if (flip) order_in = ~ord;
        if (poke) pulse_start();
        for (int i = 0; i < 3000 && vcount == 0; i++) @(negedge clk);
        for (int i = 0; i < 3000 && !cs_n; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(vcount == 1, "R6 one valid per frame", vcount, 1);
        chk(cap_a == a, "R5 channel A word", cap_a, a);
        chk(cap_b == b, "R5 channel B word", cap_b, b);
        chk(ch_a == a && ch_b == b, "R6 words held", {ch_a, ch_b}, {a, b});
        chk(last_w == T_CNV, "R1 convert pulse width", last_w, T_CNV);
        chk(rises == 32 && falls == 32, "R4 sclk edge count", rises, 32);
        chk(r3_bad == 0 && cs_falls == 1, "R3 read after busy end", r3_bad, 0);
        chk(cnv_falls == 1, "R2 one conversion per request", cnv_falls, 1);
        order_in = ord;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(cnv_n && cs_n && rd_n && !sclk && !valid && !tmo && ready,
            "R10 reset state", {cnv_n, cs_n, rd_n, sclk, valid, tmo, ready}, 7'b1110001);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // directed corners: both orders, extreme codes
        run_frame(16'hFFFF, 16'h0000, 1'b1, 4, 1'b0, 1'b0);
        run_frame(16'h8001, 16'h7FFE, 1'b0, 7, 1'b0, 1'b0);
        // R5: flip order input during read; latched order must win
        run_frame(16'hA5C3, 16'h3C5A, 1'b1, 2, 1'b1, 1'b0);
        // R2: request during read is ignored
        run_frame(16'h1234, 16'hFEDC, 1'b0, 9, 1'b0, 1'b1);

        // R9: idle with random data on the line
        clear_mon();
        repeat (50) @(negedge clk);
        chk(vcount == 0 && ch_a == 16'h1234 && ch_b == 16'hFEDC, "R9 deselected data ignored",
            {ch_a, ch_b}, {16'h1234, 16'hFEDC});

        // R2: request while busy is high is refused
        clear_mon();
        force_busy = 1'b1;
        pulse_start();
        repeat (10) @(negedge clk);
        chk(cnv_falls == 0 && ready, "R2 refused while busy", cnv_falls, 0);
        force_busy = 1'b0;
        repeat (2) @(negedge clk);

        // R7: busy stuck high
        clear_mon();
        m_hang = 1'b1;
        pulse_start();
        for (int i = 0; i < 200 && tcount == 0; i++) @(negedge clk);
        chk(tcount == 1, "R7 timeout pulse", tcount, 1);
        chk(to_cyc - fall_cyc == T_TO, "R7 timeout distance", to_cyc - fall_cyc, T_TO);
        chk(cs_falls == 0 && vcount == 0 && ready, "R7 no read after timeout", cs_falls, 0);
        m_hang = 1'b0;
        wait_idle();

        // R8: reset in the middle of a read
        clear_mon();
        next_a = 16'hDEAD; next_b = 16'hBEEF; conv_len = 5; order_in = 1'b1;
        pulse_start();
        for (int i = 0; i < 3000 && rises < 10; i++) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(cs_n && rd_n && cnv_n && !sclk && !valid, "R8 abort strobes",
            {cs_n, rd_n, cnv_n, sclk, valid}, 5'b11100);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(vcount == 0, "R8 partial frame dropped", vcount, 0);
        run_frame(16'h0F0F, 16'hF0F0, 1'b0, 6, 1'b0, 1'b0);

        // random frames
        for (int k = 0; k < 20; k++) begin
            run_frame(16'($urandom), 16'($urandom), 1'($urandom % 2),
                      2 + int'($urandom % 19), 1'b0, 1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule